// File: doc/BRIEF.md
# Power Mode Control Unit

This unit holds the power control byte of a small 8-bit microcontroller and turns it into clock enables. Software reaches it through the special-function-register bus as a whole byte at one fixed address. The byte carries a serial baud-doubling flag, two general-purpose software flags and two mode bits. One mode bit selects idle and the other selects power-down.

In idle the CPU clock enable drops, and the timers, serial port and interrupt logic keep their clock. In power-down the oscillator-run output drops, which stops every clock while storage keeps its contents. Power-down wins when both mode bits are set. A taken interrupt, an asynchronous wake request or a reset returns the core to normal run. A two-bit status output shows the current mode.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the byte reads 0x00, `pm_state` is 00 (run), `cpu_clk_en`, `per_clk_en` and `osc_run` are 1, and `baud_x2` is 0.
- R2: A byte write (`sfr_wr`) at address 0x87 stores data bits 7, 3, 2, 1 and 0. A read at 0x87 returns them in place, with bits 6 to 4 always reading 0. Reads at any other address return 0x00, and writes to any other address change nothing.
- R3: A bit-addressed write (`sfr_bit_wr` with `sfr_bit_sel`/`sfr_bit_val`) has no effect on the stored byte or on any output.
- R4: `baud_x2` equals stored bit 7 from the cycle after the write.
- R5: Stored bits 3 and 2 have no effect on `pm_state` or on any clock enable.
- R6: With bit 0 set and bit 1 clear, `pm_state` is 01 (idle), `cpu_clk_en` is 0, and `per_clk_en` and `osc_run` are 1. This takes effect from the cycle after the write, not during it.
- R7: With bit 1 set, `pm_state` is 10 (power-down) and `cpu_clk_en`, `per_clk_en` and `osc_run` are all 0.
- R8: With bits 1 and 0 both set, including when both are written in one write, the unit is in power-down as in R7.
- R9: `irq_taken` high at a clock edge clears bits 1 and 0 and keeps bits 7, 3 and 2. It overrides a write in the same cycle.
- R10: `wake_irq` high clears bits 1 and 0 at once, with no clock edge needed, and keeps bits 7, 3 and 2. Normal run resumes with `osc_run` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_bit_wr | input | 1 | Bit-addressed write strobe (ignored) |
| sfr_bit_sel | input | 3 | Bit index of a bit-addressed write |
| sfr_bit_val | input | 1 | Bit value of a bit-addressed write |
| sfr_rdata | output | 8 | Read data, combinational on the address |
| irq_taken | input | 1 | Synchronous interrupt-taken pulse |
| wake_irq | input | 1 | Asynchronous wake request |
| baud_x2 | output | 1 | Serial baud-doubling flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Timer, serial port and interrupt clock enable |
| osc_run | output | 1 | Oscillator run request |
| pm_state | output | 2 | Mode: 00 run, 01 idle, 10 power-down |

## Verification
The hardest case to reach is leaving power-down with no clock running. The wake path must act through the asynchronous input alone. To reach it, the stimulus enters power-down and then halts the bench clock on a low phase. It pulses `wake_irq` and checks the read-back byte and every enable while the clock is still stopped. Random byte writes, bit writes and interrupt pulses sweep the remaining mode transitions against a model of the byte. Directed writes cover both mode bits set together and an interrupt that coincides with a write.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter logic [7:0] REG_ADDR = 8'h87
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sfr_addr,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_wdata,
  input  logic       sfr_bit_wr,
  input  logic [2:0] sfr_bit_sel,
  input  logic       sfr_bit_val,
  output logic [7:0] sfr_rdata,
  input  logic       irq_taken,
  input  logic       wake_irq,
  output logic       baud_x2,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_run,
  output logic [1:0] pm_state
);

  logic baud_q, gf1_q, gf0_q, pd_q, idl_q;

  wire hit     = (sfr_addr == REG_ADDR);
  wire byte_wr = sfr_wr && hit;
  wire unused_in = ^{sfr_wdata[6:4], sfr_bit_wr, sfr_bit_sel, sfr_bit_val};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       {baud_q, gf1_q, gf0_q} <= 3'b000;
    else if (byte_wr) {baud_q, gf1_q, gf0_q} <= {sfr_wdata[7], sfr_wdata[3], sfr_wdata[2]};

  // mode bits also clear asynchronously, since no clock runs in power-down
  always_ff @(posedge clk or negedge rst_n or posedge wake_irq)
    if (!rst_n)         {pd_q, idl_q} <= 2'b00;
    else if (wake_irq)  {pd_q, idl_q} <= 2'b00;
    else if (irq_taken) {pd_q, idl_q} <= 2'b00;
    else if (byte_wr)   {pd_q, idl_q} <= sfr_wdata[1:0];

  assign pm_state   = pd_q ? 2'b10 : (idl_q ? 2'b01 : 2'b00);
  assign osc_run    = ~pd_q;
  assign per_clk_en = ~pd_q;
  assign cpu_clk_en = ~pd_q & ~idl_q;
  assign baud_x2    = baud_q;
  assign sfr_rdata  = hit ? {baud_q, 3'b000, gf1_q, gf0_q, pd_q, idl_q} : 8'h00;

  // R8
  both_set_pd_chk: assert property (@(posedge clk) disable iff (!rst_n || wake_irq)
    (byte_wr && sfr_wdata[1:0] == 2'b11 && !irq_taken) |=> (pm_state == 2'b10 && !osc_run && !cpu_clk_en));

  // R6
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n || wake_irq)
    (byte_wr && sfr_wdata[1:0] == 2'b01 && !irq_taken) |=> (!cpu_clk_en && per_clk_en && osc_run));

  // R3
  bit_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n || wake_irq)
    (sfr_bit_wr && !byte_wr && !irq_taken) |=> $stable({baud_x2, pm_state, cpu_clk_en, osc_run}));

  // R9
  irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n || wake_irq)
    irq_taken |=> (pm_state == 2'b00 && cpu_clk_en && per_clk_en && osc_run));

  // R4
  baud_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr |=> (baud_x2 == $past(sfr_wdata[7])));

endmodule

// File: tb/sim_pwr_mode_ctl.sv
module sim_pwr_mode_ctl;
  logic clk = 1'b0, clk_on = 1'b1, rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  logic sfr_wr = 0, sfr_bit_wr = 0, sfr_bit_val = 0, irq_taken = 0, wake_irq = 0;
  logic [2:0] sfr_bit_sel = 3'd0;
  logic [7:0] sfr_rdata;
  logic baud_x2, cpu_clk_en, per_clk_en, osc_run;
  logic [1:0] pm_state;
  int total = 0, bad = 0;
  logic [7:0] model = 8'h00;

  pwr_mode_ctl u0 (.clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_bit_wr(sfr_bit_wr), .sfr_bit_sel(sfr_bit_sel),
    .sfr_bit_val(sfr_bit_val), .sfr_rdata(sfr_rdata), .irq_taken(irq_taken),
    .wake_irq(wake_irq), .baud_x2(baud_x2), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_run(osc_run), .pm_state(pm_state));

  initial forever begin #2; if (clk_on) clk = ~clk; end

  function automatic logic [1:0] exp_mode(logic [7:0] v);
    return v[1] ? 2'b10 : (v[0] ? 2'b01 : 2'b00);
  endfunction

  function automatic logic [3:0] exp_en(logic [7:0] v);
    return {v[7], ~v[1] & ~v[0], ~v[1], ~v[1]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    sfr_wr = 0; sfr_bit_wr = 0; irq_taken = 0; sfr_addr = 8'h87;
    #1;
    chk({req, " rdata"}, sfr_rdata, model & 8'h8F);
    chk({req, " mode"}, pm_state, exp_mode(model));
    chk({req, " enables"}, {baud_x2, cpu_clk_en, per_clk_en, osc_run}, exp_en(model));
  endtask

  task automatic byte_wr(logic [7:0] a, logic [7:0] d, logic irq);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1; irq_taken = irq;
    #1;
    if (a == 8'h87) begin
      // R6 R7: no mode change inside the writing cycle
      chk("R6 same-cycle mode", pm_state, exp_mode(model));
      if (irq) model = {d[7], 3'b000, d[3:2], 2'b00};
      else     model = d & 8'h8F;
    end else if (irq) model[1:0] = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    #300_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1DE5));
    repeat (3) @(negedge clk);
    #1; chk("R1 reset mode", pm_state, 2'b00);
    rst_n = 1;
    check_all("R1 reset");

    // R2: other address, reads elsewhere
    byte_wr(8'h86, 8'hFF, 0); check_all("R2 write other address");
    sfr_addr = 8'h88; #1; chk("R2 read other address", sfr_rdata, 8'h00);
    // R2 R4 R5: reserved bits, baud and flags only
    byte_wr(8'h87, 8'hFC, 0); check_all("R2 R4 R5 flags");
    // R3: bit write cannot enter idle
    @(negedge clk); sfr_bit_wr = 1; sfr_bit_sel = 3'd0; sfr_bit_val = 1; sfr_addr = 8'h87;
    @(negedge clk); check_all("R3 bit write ignored");
    // R6
    byte_wr(8'h87, 8'h01, 0); check_all("R6 idle");
    // R9
    byte_wr(8'h80, 8'h00, 1); check_all("R9 irq clears idle");
    // R8 both in one write
    byte_wr(8'h87, 8'h8B, 0); check_all("R8 both set");
    // R9 irq wins over a simultaneous write
    byte_wr(8'h87, 8'h06, 1); check_all("R9 irq over write");
    // R7 then R10 with the clock stopped
    byte_wr(8'h87, 8'h86, 0); check_all("R7 power-down");
    @(negedge clk); clk_on = 0; #20;
    wake_irq = 1; #3; model[1:0] = 2'b00;
    sfr_addr = 8'h87; #1;
    chk("R10 rdata no clock", sfr_rdata, model & 8'h8F);
    chk("R10 osc_run no clock", osc_run, 1);
    chk("R10 mode no clock", pm_state, 2'b00);
    wake_irq = 0; #3; clk_on = 1;
    @(negedge clk); check_all("R10 after wake");

    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 5) byte_wr(($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h87, 8'($urandom), $urandom_range(0, 7) == 0);
      else if (op < 7) begin
        @(negedge clk); sfr_addr = 8'h87; sfr_bit_wr = 1;
        sfr_bit_sel = 3'($urandom); sfr_bit_val = 1'($urandom);
        @(negedge clk);
      end else if (op < 9) byte_wr(8'h00, 8'h00, 1);
      else begin
        @(negedge clk); wake_irq = 1; #1; model[1:0] = 2'b00; wake_irq = 0;
        @(negedge clk);
      end
      check_all("R2 R3 R5 R6 R7 R8 R9 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule